// File: doc/BRIEF.md
# Programmable High/Low Clock Divider

This block derives an output clock from a 24 MHz reference clock. Two 8-bit settings give the number of reference cycles the output spends high and the number it spends low. The output period is therefore their sum, and the duty cycle can be set anywhere from an even square wave down to a single one-cycle pulse. When both settings are zero, the reference clock itself goes straight to the output. When the enable is off, the output rests low.

A small state machine runs the block. Its states are:

- `ST_OFF`: disabled; the output is low.
- `ST_PASS`: pass-through.
- `ST_HIGH`: high phase of a divided period.
- `ST_LOW`: low phase of a divided period.
- `ST_HOLD_HI`: only the high count is non-zero, so the output is steady high.
- `ST_HOLD_LO`: only the low count is non-zero, so the output is steady low.

The transitions are:

- **disable**: any state goes to `ST_OFF` at a clock edge that sees the enable low.
- **boundary load**: a period boundary picks the next state from the live settings. A boundary happens from `ST_OFF` when enabled, from `ST_LOW` when its count runs out, and on every cycle in `ST_PASS`, `ST_HOLD_HI` and `ST_HOLD_LO`. When both settings are non-zero, the next state is `ST_HIGH`.
- **phase flip**: `ST_HIGH` goes to `ST_LOW` when the high count runs out.
- **count**: `ST_HIGH` and `ST_LOW` stay where they are while their count is not yet exhausted.

A change to the settings in the middle of a divided period only takes effect at the next boundary.

Top module: `hilo_clk_divider`

## Requirements
- R1: At any clock edge that samples `enable` low, the block enters the off state. From that edge until the next one, `clk_out` is 0.
- R2: While enabled with `high_len` = 0 and `low_len` = 0, `clk_out` follows `ref_clk`. It is high in the high half of the reference cycle and low in the low half.
- R3: Take both settings non-zero and the block enabled from the off state. Number the reference cycles from 0, starting with the first edge that samples `enable` high. In cycle i, `clk_out` is 1 when (i mod (high_len+low_len)) < high_len, and 0 otherwise.
- R4: While enabled with `high_len` non-zero and `low_len` = 0, `clk_out` is held at 1.
- R5: While enabled with `high_len` = 0 and `low_len` non-zero, `clk_out` is held at 0.
- R6: Settings that change during a divided period are ignored until the period ends. The new pattern starts at the first cycle after the last low cycle of the old period.
- R7: A setting of 1 in either field gives exactly one reference cycle in that phase, so the output is a single high-going or low-going pulse per period.
- R8: Each field is 8 bits, so the longest period is 510 reference cycles (255 high, 255 low).
- R9: While reset is asserted, and after it is released before any enable, `clk_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock (24 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the divider; when low the output is held low |
| high_len | input | 8 | Reference cycles the output stays high per period |
| low_len | input | 8 | Reference cycles the output stays low per period |
| clk_out | output | 1 | Generated clock |

## Verification
A wrong state or phase count shows at `clk_out` within one period. A phase that is too long or too short moves every following edge, so a sample taken once per reference cycle catches a single-count error by the end of the first affected phase. A shadow register that loads at the wrong time shows up on the first cycle after the intended boundary, because the pattern then switches early or late. A wrong decode of the zero cases shows on the very first cycle after enable. Pass-through errors are caught by sampling both halves of the reference cycle.

// File: rtl/hilo_clk_pkg.sv
package hilo_clk_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_PASS,
        ST_HIGH,
        ST_LOW,
        ST_HOLD_HI,
        ST_HOLD_LO
    } hl_state_t;
endpackage

// File: rtl/hl_shadow.sv
module hl_shadow #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] hi_in,
    input  logic [W-1:0] lo_in,
    output logic [W-1:0] hi_q,
    output logic [W-1:0] lo_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (load) begin
            hi_q <= hi_in;
            lo_q <= lo_in;
        end
    end

    // settings are only captured at a period boundary
    p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

// File: rtl/hl_phase_timer.sv
module hl_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // a phase never counts past its end
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (cnt_q != '0));

    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/hl_div_fsm.sv
module hl_div_fsm
    import hilo_clk_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic [W-1:0] hi_in,
    input  logic [W-1:0] lo_in,
    input  logic [W-1:0] lo_act,
    input  logic         tmr_zero,
    output logic         shd_load,
    output logic         tmr_load,
    output logic [W-1:0] tmr_val,
    output logic         tmr_dec,
    output logic         level,
    output hl_state_t    state
);
    hl_state_t state_d;
    logic      boundary;
    logic      hi_nz;
    logic      lo_nz;

    assign hi_nz = (hi_in != '0);
    assign lo_nz = (lo_in != '0);

    always_comb begin
        unique case (state)
            ST_OFF:     boundary = 1'b1;
            ST_PASS:    boundary = 1'b1;
            ST_HOLD_HI: boundary = 1'b1;
            ST_HOLD_LO: boundary = 1'b1;
            ST_LOW:     boundary = tmr_zero;
            ST_HIGH:    boundary = 1'b0;
            default:    boundary = 1'b1;
        endcase
    end

    always_comb begin
        state_d  = state;
        shd_load = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        tmr_dec  = 1'b0;
        if (!enable) begin
            state_d = ST_OFF;
        end else if (boundary) begin
            shd_load = 1'b1;
            if (hi_nz && lo_nz) begin
                state_d  = ST_HIGH;
                tmr_load = 1'b1;
                tmr_val  = hi_in - 1'b1;
            end else if (hi_nz) begin
                state_d = ST_HOLD_HI;
            end else if (lo_nz) begin
                state_d = ST_HOLD_LO;
            end else begin
                state_d = ST_PASS;
            end
        end else if (state == ST_HIGH && tmr_zero) begin
            state_d  = ST_LOW;
            tmr_load = 1'b1;
            tmr_val  = lo_act - 1'b1;
        end else begin
            tmr_dec = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_OFF;
        else
            state <= state_d;
    end

    always_comb begin
        unique case (state)
            ST_HIGH, ST_HOLD_HI: level = 1'b1;
            default:             level = 1'b0;
        endcase
    end

    p_off_when_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state == ST_OFF));

    p_high_then_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == ST_HIGH && tmr_zero) |=> (state == ST_LOW));

    p_low_ends_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOW && !tmr_zero && enable) |=> (state == ST_LOW));

    p_no_enter_low_direct_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_HIGH && state != ST_LOW) |=> (state != ST_LOW));
endmodule

// File: rtl/hilo_clk_divider.sv
module hilo_clk_divider
    import hilo_clk_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         ref_clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic [W-1:0] high_len,
    input  logic [W-1:0] low_len,
    output logic         clk_out
);
    logic         shd_load;
    logic         tmr_load;
    logic         tmr_dec;
    logic         tmr_zero;
    logic         level;
    logic [W-1:0] tmr_val;
    logic [W-1:0] hi_act;
    logic [W-1:0] lo_act;
    hl_state_t    state;

    hl_shadow #(.W(W)) u_shadow (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .load  (shd_load),
        .hi_in (high_len),
        .lo_in (low_len),
        .hi_q  (hi_act),
        .lo_q  (lo_act)
    );

    hl_phase_timer #(.W(W)) u_timer (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .dec      (tmr_dec),
        .zero     (tmr_zero)
    );

    hl_div_fsm #(.W(W)) u_fsm (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .hi_in    (high_len),
        .lo_in    (low_len),
        .lo_act   (lo_act),
        .tmr_zero (tmr_zero),
        .shd_load (shd_load),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .tmr_dec  (tmr_dec),
        .level    (level),
        .state    (state)
    );

    assign clk_out = (state == ST_PASS) ? ref_clk : level;

    p_steady_high_r4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (state == ST_HOLD_HI) |-> clk_out);

    p_steady_low_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (state == ST_HOLD_LO) |-> !clk_out);

    p_divided_nonzero_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (state == ST_HIGH) |-> (hi_act != '0 && lo_act != '0));
endmodule

// File: tb/hilo_clk_divider_tb.sv
module hilo_clk_divider_tb;
    logic       ref_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic       enable  = 1'b0;
    logic [7:0] high_len = '0;
    logic [7:0] low_len  = '0;
    logic       clk_out;
    int         n_chk  = 0;
    int         n_fail = 0;

    always #10 ref_clk = ~ref_clk;

    hilo_clk_divider u_dut (
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .high_len (high_len),
        .low_len  (low_len),
        .clk_out  (clk_out)
    );

    function automatic logic exp_level(int hi, int lo, int i);
        if (hi == 0) return 1'b0;
        if (lo == 0) return 1'b1;
        return ((i % (hi + lo)) < hi);
    endfunction

    task automatic check(logic act, logic exp, string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: clk_out=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic stop_run();
        @(negedge ref_clk);
        enable = 1'b0;
        @(posedge ref_clk);
        #5 check(clk_out, 1'b0, "R1");
        #10 check(clk_out, 1'b0, "R1");
    endtask

    task automatic run(int hi, int lo, int ncyc, string req);
        @(negedge ref_clk);
        high_len = hi[7:0];
        low_len  = lo[7:0];
        enable   = 1'b1;
        for (int i = 0; i < ncyc; i++) begin
            @(posedge ref_clk);
            if (hi == 0 && lo == 0) begin
                #5  check(clk_out, 1'b1, "R2");
                #10 check(clk_out, 1'b0, "R2");
            end else begin
                #5 check(clk_out, exp_level(hi, lo, i), req);
            end
        end
        stop_run();
    endtask

    task automatic run_change(int h0, int l0, int h1, int l1, int at, int ncyc);
        @(negedge ref_clk);
        high_len = h0[7:0];
        low_len  = l0[7:0];
        enable   = 1'b1;
        for (int i = 0; i < ncyc; i++) begin
            @(posedge ref_clk);
            #5;
            if (i < h0 + l0)
                check(clk_out, exp_level(h0, l0, i), "R6");
            else
                check(clk_out, exp_level(h1, l1, i - h0 - l0), "R6");
            if (i == at) begin
                @(negedge ref_clk);
                high_len = h1[7:0];
                low_len  = l1[7:0];
            end
        end
        stop_run();
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        #15 check(clk_out, 1'b0, "R9");
        #20 check(clk_out, 1'b0, "R9");
        rst_n = 1'b1;
        repeat (2) @(posedge ref_clk);
        #5 check(clk_out, 1'b0, "R9");

        run(4, 4, 20, "R3");
        run(2, 0, 10, "R4");
        run(0, 3, 10, "R5");
        run(0, 0, 8, "R2");
        run(1, 6, 21, "R7");
        run(6, 1, 21, "R7");
        run(1, 1, 10, "R7");
        run(255, 255, 1030, "R8");
        run_change(3, 5, 6, 2, 2, 30);
        run_change(2, 7, 1, 3, 5, 30);

        for (int k = 0; k < 40; k++) begin
            int mode;
            int hi;
            int lo;
            mode = int'($urandom % 8);
            hi = 1 + int'($urandom % ((mode < 4) ? 255 : 12));
            lo = 1 + int'($urandom % ((mode < 4) ? 255 : 12));
            case (mode)
                0: run(0, 0, 4, "R2");
                1: run(hi, 0, 6, "R4");
                2: run(0, lo, 6, "R5");
                3: run(hi, lo, 2 * (hi + lo) + 3, "R8");
                default: run(hi, lo, 2 * (hi + lo) + 3, "R3");
            endcase
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule